// File: doc/BRIEF.md
# Multi-Hart Run Control Unit

This block holds the debug request state for a set of harts and turns control-register writes into per-hart halt, resume and reset requests. It drives per-hart halt, resume, reset and halt-on-reset outputs, and collects the per-hart halted, unavailable and reset-done inputs into summary status bits. A debug front end reaches it through a small register port with four word addresses.

The front end picks harts in one of two ways. It can give a single hart index. It can also load a hart array mask, a 32-bit window at a time, through a window-select register and a window register. When the array-select control bit is set, every hart whose mask bit is 1 is picked as well as the indexed hart.

Every request command acts on the harts that are picked. The status word reports "any" and "all" summaries over those harts for each of these properties: nonexistent, unavailable, running, halted, resume acknowledged and reset seen. The whole unit stays in reset while its active bit is 0.

Top module: `hart_runctl`

## Requirements
- R1: A control write with the halt bit (bit 1) at 1 sets the halt-pending flag of every picked hart; a control write with it at 0 clears the flag for the picked harts. Output `halt_req_o[n]` is the pending flag masked off while `halted_i[n]` is 1, so a halted hart sees no halt request.
- R2: A control write with the resume bit (bit 2) at 1 clears the resume-ack flag of every picked hart and raises `resume_req_o[n]` for each picked hart that is halted and available. Picked harts that are running get no request. When a hart with a pending resume is in the running state at a clock edge, its request drops and its resume-ack flag sets on that edge.
- R3: A one-cycle pulse on `rst_done_i[n]` sets a sticky reset-seen flag for hart n. A control write with the acknowledge bit (bit 4) at 1 clears the flag for the picked harts. If a pulse and an acknowledge fall on the same edge, the flag stays set.
- R4: A control write with bit 5 at 1 sets the halt-on-reset flag, and a write with bit 6 at 1 clears it, for the picked harts. When both bits are 1, the clear wins. The flags appear on `halt_on_reset_o`.
- R5: The mask is written and read at address 3, in the 32-hart window chosen by address 2. Only the implemented window-select bits can be written, and windows with no harts read as 0. With array-select (control bit 7) at 1, hart n is picked when its mask bit is 1 or when it is the indexed hart. Changing array-select leaves the mask contents unchanged.
- R6: The status word at address 1 has these bit pairs, each given as (any, all): bits 0 and 1 nonexistent, bits 2 and 3 unavailable, bits 4 and 5 running, bits 6 and 7 halted, bits 8 and 9 resume-ack, bits 10 and 11 reset-seen. An "all" bit is 1 only when the property holds for every picked hart.
- R7: The hart index sits in control bits 8 and up, and only its IDXW low bits can be written. An index of NHARTS or more is a nonexistent hart: it sets any-nonexistent, and it clears every other "all" bit.
- R8: After power-up reset, and while the active bit (control bit 0) is 0, all per-hart flags, the mask, the index, array-select and hart-reset are 0. A write that clears the active bit clears them on the same edge. A write that finds the active bit at 0 changes only the active bit.
- R9: Each existing hart is in exactly one state, chosen by priority: unavailable when `unavail_i` is 1, otherwise halted when `halted_i` is 1, otherwise running.
- R10: Control bit 3 (hart reset) reads back as written. While it is 1, `hart_rst_o` is a level equal to the set of picked harts.
- R11: Address 0 is the control register. It reads back the active bit, hart reset, array-select and the index. The request bits 1, 2, 4, 5 and 6 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register word address |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `req_addr` |
| halted_i | input | NHARTS | Per-hart halted indication |
| unavail_i | input | NHARTS | Per-hart unavailable indication |
| rst_done_i | input | NHARTS | Per-hart reset-complete pulse |
| halt_req_o | output | NHARTS | Per-hart halt request |
| resume_req_o | output | NHARTS | Per-hart resume request |
| hart_rst_o | output | NHARTS | Per-hart reset level |
| halt_on_reset_o | output | NHARTS | Per-hart halt-on-reset flag |

## Verification
Every request flag sits one register away from a port, so a wrong flag shows up on the request outputs, or in the status word, in the cycle after the write that set it. A wrong resume-ack or reset-seen flag is only visible through the status summaries, and only while a hart that carries it is picked. For that reason the bench moves the selection across single indices, masks and nonexistent indices before it reads status. A fault in the selection decode shows up at once as a wrong any/all pair. A fault in mask storage shows up only once array-select is turned on, or when the window is read back.

// File: rtl/hart_runctl.sv
module hart_runctl #(
  parameter int NHARTS = 5,
  parameter int IDXW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rdata,
  input  logic [NHARTS-1:0] halted_i,
  input  logic [NHARTS-1:0] unavail_i,
  input  logic [NHARTS-1:0] rst_done_i,
  output logic [NHARTS-1:0] halt_req_o,
  output logic [NHARTS-1:0] resume_req_o,
  output logic [NHARTS-1:0] hart_rst_o,
  output logic [NHARTS-1:0] halt_on_reset_o
);
  localparam int NWIN = (NHARTS + 31) / 32;
  localparam int WSW  = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int PADW = (1 << WSW) * 32;

  logic            active, hrst, asel;
  logic [IDXW-1:0] idx;
  logic [WSW-1:0]  wsel;
  logic [NHARTS-1:0] mask, hpend, rpend, ack, seen, hor;
  logic [NHARTS-1:0] idxhot, cmdhot, sel, cs, msel;
  logic [NHARTS-1:0] st_run, st_halt;
  logic [11:0] stat;

  wire wr      = req_valid & req_write;
  wire wr_ctl  = wr & (req_addr == 2'd0);
  wire wr_wsel = wr & (req_addr == 2'd2);
  wire wr_win  = wr & (req_addr == 2'd3);
  wire clr_all = !active || (wr_ctl && !req_wdata[0]);
  wire do_cmd  = wr_ctl & active & req_wdata[0];
  wire [IDXW-1:0] w_idx = req_wdata[8 +: IDXW];

  generate
    for (genvar n = 0; n < NHARTS; n++) begin : g_hart
      assign idxhot[n] = (idx == IDXW'(n));
      assign cmdhot[n] = (w_idx == IDXW'(n));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask[n] <= 1'b0;
        else if (clr_all) mask[n] <= 1'b0;
        else if (wr_win && wsel == WSW'(n / 32)) mask[n] <= req_wdata[n % 32];
      end
    end
  endgenerate

  assign msel    = asel ? mask : '0;
  assign sel     = idxhot | msel;
  assign cs      = cmdhot | (req_wdata[7] ? mask : '0);
  assign st_halt = ~unavail_i & halted_i;
  assign st_run  = ~unavail_i & ~halted_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else if (wr_ctl) active <= req_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrst <= 1'b0; asel <= 1'b0; idx <= '0; wsel <= '0;
      hpend <= '0; rpend <= '0; ack <= '0; seen <= '0; hor <= '0;
    end else if (clr_all) begin
      hrst <= 1'b0; asel <= 1'b0; idx <= '0; wsel <= '0;
      hpend <= '0; rpend <= '0; ack <= '0; seen <= '0; hor <= '0;
    end else begin
      if (do_cmd) begin
        hrst  <= req_wdata[3];
        asel  <= req_wdata[7];
        idx   <= w_idx;
        hpend <= req_wdata[1] ? (hpend | cs) : (hpend & ~cs);
      end
      if (wr_wsel) wsel <= req_wdata[WSW-1:0];
      rpend <= (rpend & ~st_run) | ((do_cmd && req_wdata[2]) ? (cs & st_halt) : '0);
      ack   <= ((do_cmd && req_wdata[2]) ? (ack & ~cs) : ack) | (rpend & st_run);
      seen  <= ((do_cmd && req_wdata[4]) ? (seen & ~cs) : seen) | rst_done_i;
      if (do_cmd && req_wdata[6])      hor <= hor & ~cs;
      else if (do_cmd && req_wdata[5]) hor <= hor | cs;
    end
  end

  wire idx_nx = ({1'b0, idx} >= (IDXW+1)'(NHARTS));
  wire all_ok = !idx_nx;

  assign stat[0]  = idx_nx;
  assign stat[1]  = idx_nx & ~|msel;
  assign stat[2]  = |(sel & unavail_i);
  assign stat[3]  = all_ok & (&(~sel | unavail_i));
  assign stat[4]  = |(sel & st_run);
  assign stat[5]  = all_ok & (&(~sel | st_run));
  assign stat[6]  = |(sel & st_halt);
  assign stat[7]  = all_ok & (&(~sel | st_halt));
  assign stat[8]  = |(sel & ack);
  assign stat[9]  = all_ok & (&(~sel | ack));
  assign stat[10] = |(sel & seen);
  assign stat[11] = all_ok & (&(~sel | seen));

  wire [PADW-1:0] maskpad = PADW'(mask);

  always_comb begin
    case (req_addr)
      2'd0:    rdata = 32'({idx, asel, 3'b000, hrst, 2'b00, active});
      2'd1:    rdata = 32'(stat);
      2'd2:    rdata = 32'(wsel);
      default: rdata = maskpad[wsel*32 +: 32];
    endcase
  end

  assign halt_req_o      = hpend & ~halted_i;
  assign resume_req_o    = rpend;
  assign hart_rst_o      = hrst ? sel : '0;
  assign halt_on_reset_o = hor;
endmodule

// File: rtl/hart_runctl_chk.sv
module hart_runctl_chk #(
  parameter int NHARTS = 5,
  parameter int IDXW   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_addr,
  input logic [31:0]       req_wdata,
  input logic [NHARTS-1:0] mask,
  input logic [NHARTS-1:0] ack,
  input logic [NHARTS-1:0] seen,
  input logic [11:0]       stat,
  input logic [NHARTS-1:0] halted_i,
  input logic [NHARTS-1:0] unavail_i,
  input logic [NHARTS-1:0] rst_done_i,
  input logic [NHARTS-1:0] halt_req_o,
  input logic [NHARTS-1:0] resume_req_o,
  input logic [NHARTS-1:0] hart_rst_o,
  input logic [NHARTS-1:0] halt_on_reset_o
);
  wire [NHARTS-1:0] run = ~unavail_i & ~halted_i;

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (halt_req_o == '0 && resume_req_o == '0 && hart_rst_o == '0 && halt_on_reset_o == '0));

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (resume_req_o & run) != '0) |=>
      (!active || ((ack & $past(resume_req_o & run)) == $past(resume_req_o & run))));

  assert_seen_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rst_done_i != '0) |=>
      (!active || ((seen & $past(rst_done_i)) == $past(rst_done_i))));

  assert_mask_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && req_valid && req_write && req_addr == 2'd0 && req_wdata[0]) |=> $stable(mask));

  assert_all_implies_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[3] -> stat[2]) && (stat[5] -> stat[4]) && (stat[7] -> stat[6]) &&
    (stat[9] -> stat[8]) && (stat[11] -> stat[10]));

  assert_no_halt_to_halted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req_o & halted_i) == '0);
endmodule

bind hart_runctl hart_runctl_chk #(.NHARTS(NHARTS), .IDXW(IDXW)) chk (
  .clk(clk), .rst_n(rst_n), .active(active), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .mask(mask), .ack(ack), .seen(seen), .stat(stat),
  .halted_i(halted_i), .unavail_i(unavail_i), .rst_done_i(rst_done_i),
  .halt_req_o(halt_req_o), .resume_req_o(resume_req_o),
  .hart_rst_o(hart_rst_o), .halt_on_reset_o(halt_on_reset_o)
);

// File: tb/hart_runctl_test.sv
module hart_runctl_test;
  localparam int N = 5;
  localparam logic [31:0] ACT = 1, HALT = 2, RES = 4, HRST = 8, ACK = 16,
                          HSET = 32, HCLR = 64, ASEL = 128;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_addr = 0;
  logic [31:0] req_wdata = 0, rdata;
  logic [N-1:0] halted_i = 0, unavail_i = 0, rst_done_i = 0;
  logic [N-1:0] halt_req_o, resume_req_o, hart_rst_o, halt_on_reset_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  hart_runctl uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] exp_st(int idx, bit asel, logic [N-1:0] m,
                                         logic [N-1:0] h, logic [N-1:0] u);
    bit nx = idx >= N;
    bit anyu = 0, allu = !nx, anyr = 0, allr = !nx, anyh = 0, allh = !nx, msel = 0;
    for (int n = 0; n < N; n++) begin
      bit s = (idx == n) || (asel && m[n]);
      bit su = u[n], sh = h[n] && !u[n], sr = !h[n] && !u[n];
      if (asel && m[n]) msel = 1;
      if (s) begin
        anyu |= su; allu &= su; anyr |= sr; allr &= sr; anyh |= sh; allh &= sh;
      end
    end
    return {20'b0, 4'b0, allh, anyh, allr, anyr, allu, anyu, nx && !msel, nx};
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, d); chk("R8 ctl after reset", d, 0);
    rd(2'd1, d); chk("R6 status after reset", d, 32'h30);
    chk("R8 outputs after reset", {halt_req_o, resume_req_o, hart_rst_o, halt_on_reset_o}, 0);

    wr(2'd0, 32'h0000_0300 | HRST);
    rd(2'd0, d); chk("R8 inactive write ignored", d, 0);
    wr(2'd0, ACT);
    wr(2'd0, ACT | 32'h00FF_FF00);
    rd(2'd0, d); chk("R7 index width readback", d, ACT | (7 << 8));
    wr(2'd0, ACT | RES | HALT | ACK | HSET | (2 << 8));
    rd(2'd0, d); chk("R11 request bits read 0", d, ACT | (2 << 8));
    wr(2'd0, ACT);

    for (int i = 0; i < 8; i++) begin
      for (int m = 0; m < 32; m += 3) begin
        for (int a = 0; a < 2; a++) begin
          logic [N-1:0] h = N'(m * 7 + i * 3);
          logic [N-1:0] u = N'((m * 5) ^ (i * 9) ^ 5'h12);
          wr(2'd3, 32'(m));
          wr(2'd0, ACT | (a ? ASEL : 0) | (32'(i) << 8));
          halted_i = h; unavail_i = u;
          rd(2'd1, d);
          chk("R6 R7 R9 status sweep", d, exp_st(i, a[0], N'(m), h, u));
        end
      end
    end
    halted_i = 0; unavail_i = 0;

    wr(2'd3, 32'b00101);
    wr(2'd0, ACT | HALT | ASEL | (1 << 8));
    chk("R1 halt to picked harts", 32'(halt_req_o), 32'b00111);
    @(negedge clk); halted_i = 5'b00010; #1;
    chk("R1 halted hart ignores", 32'(halt_req_o), 32'b00101);
    wr(2'd0, ACT | ASEL | (1 << 8));
    chk("R1 halt cleared by write 0", 32'(halt_req_o), 0);

    halted_i = 5'b00110;
    wr(2'd3, 32'b01100);
    wr(2'd0, ACT | RES | ASEL | (1 << 8));
    chk("R2 resume to halted picked", 32'(resume_req_o), 32'b00110);
    rd(2'd1, d); chk("R2 ack low while pending", d[9:8], 0);
    halted_i = 0;
    rd(2'd1, d);
    chk("R2 resume dropped", 32'(resume_req_o), 0);
    chk("R2 any ack all ack over 1..3", d[9:8], 2'b01);
    wr(2'd0, ACT | (1 << 8));
    rd(2'd1, d); chk("R2 all ack hart1", d[9:8], 2'b11);

    wr(2'd0, ACT);
    @(negedge clk); rst_done_i = 5'b10001;
    @(negedge clk); rst_done_i = 0;
    rd(2'd1, d); chk("R3 seen hart0", d[11:10], 2'b11);
    wr(2'd0, ACT | (1 << 8));
    rd(2'd1, d); chk("R3 not seen hart1", d[11:10], 2'b00);
    wr(2'd0, ACT | ACK);
    rd(2'd1, d); chk("R3 ack clears hart0", d[11:10], 2'b00);
    wr(2'd0, ACT | (4 << 8));
    rd(2'd1, d); chk("R3 hart4 still seen", d[11:10], 2'b11);

    wr(2'd0, ACT | HSET | (2 << 8));
    chk("R4 set hart2", 32'(halt_on_reset_o), 32'b00100);
    wr(2'd3, 32'b00011);
    wr(2'd0, ACT | HSET | ASEL | (4 << 8));
    chk("R4 set via mask", 32'(halt_on_reset_o), 32'b10111);
    wr(2'd0, ACT | HCLR | (2 << 8));
    chk("R4 clear hart2", 32'(halt_on_reset_o), 32'b10011);
    wr(2'd0, ACT | HSET | HCLR);
    chk("R4 clear wins", 32'(halt_on_reset_o), 32'b10010);

    wr(2'd0, ACT | HRST | (3 << 8));
    chk("R10 reset level hart3", 32'(hart_rst_o), 32'b01000);
    repeat (5) @(negedge clk);
    chk("R10 reset held", 32'(hart_rst_o), 32'b01000);
    rd(2'd0, d); chk("R10 R11 ctl readback", d, ACT | HRST | (3 << 8));
    wr(2'd0, ACT | (3 << 8));
    chk("R10 reset released", 32'(hart_rst_o), 0);

    wr(2'd3, 32'b10110);
    wr(2'd0, ACT | ASEL);
    rd(2'd3, d); chk("R5 mask kept asel on", d, 32'b10110);
    wr(2'd0, ACT);
    rd(2'd3, d); chk("R5 mask kept asel off", d, 32'b10110);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R5 window select width", d, 1);
    rd(2'd3, d); chk("R5 empty window reads 0", d, 0);
    wr(2'd2, 0);

    wr(2'd0, 0);
    rd(2'd0, d); chk("R8 deactivated ctl", d, 0);
    chk("R8 hor cleared", 32'(halt_on_reset_o), 0);
    wr(2'd0, ACT);
    wr(2'd0, ACT | (4 << 8));
    rd(2'd1, d); chk("R8 seen cleared", d[11:10], 0);
    rd(2'd3, d); chk("R8 mask cleared", d, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule